// File: doc/BRIEF.md
# Byte-to-Block Control Type Generator

This block takes an eight-byte MAC-side transmit word, with one control flag per byte, and turns it into a 64-bit block and a 4-bit block-type code. A downstream lane distributor and 64B/66B encoder read only the type code to learn what the block holds. The code can mean plain data, a frame start, a frame end at a given byte position, idle/control, or one of the special alignment, error and null blocks. The code value carries the start or terminate byte position directly, so the eight control flags never travel past this block.

Byte i of a word is `data_i[8*i+7:8*i]` and its flag is `ctrl_i[i]`. A set flag marks a control character. The characters recognised are: start 0xFB, terminate 0xFD, error 0xFE, alignment 0x7C, null 0x9C. Any other control value, idle 0x07 for example, is a plain control character. A control byte holding a value other than start or terminate is called "plain" below. The output is registered, with one cycle of latency.

Top module: `blk_type_gen`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `type_o` and `block_o` are all zero.
- R2: `valid_o` equals `valid_i` of the previous clock cycle. A block and its type appear one cycle after the accepted input.
- R3: A word with all eight control flags clear gives type 4'b0000. The block is the input word unchanged.
- R4: Flags 8'b0000_0001 with byte 0 = 0xFB give type 4'b1001. The block is unchanged.
- R5: Flags 8'b0001_1111 with bytes 0..3 plain and byte 4 = 0xFB give type 4'b1010. The block is unchanged.
- R6: A terminate at byte k (k = 0..7) gives type 8-k, from 4'b1000 for k=0 down to 4'b0001 for k=7. This needs three conditions: the flags equal 8'hFF shifted left by k, byte k is 0xFD, and every byte above k is plain. The block is unchanged.
- R7: All eight flags set, with all bytes plain and none of the uniform cases of R8, gives type 4'b1111. The block is unchanged.
- R8: All eight flags set with every byte equal gives a special type: all 0x7C gives 4'b1011, all 0x9C gives 4'b1101, and all 0xFE gives 4'b1100.
- R9: Any other flag/byte combination gives type 4'b1100, and every byte of the block becomes 0xFE.
- R10: While `valid_i` is low, `type_o` and `block_o` keep their previous values.
- R11: Type code 4'b1110 is reserved for ordered sets and is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid |
| data_i | input | 64 | Eight input bytes, byte 0 in the low bits |
| ctrl_i | input | 8 | Per-byte control flags |
| valid_o | output | 1 | Output block is valid |
| block_o | output | 64 | Registered 64-bit block |
| type_o | output | 4 | Registered block-type code |

## Verification
A fault in classification or priority shows up as a wrong `type_o` in the cycle after the offending word, with no delay beyond the single output register. A missing error fill shows up as a non-0xFE byte in that same cycle. A fault in the hold or valid path shows up on the first idle cycle, as changed outputs or a `valid_o` out of step with `valid_i`. The sweep covers all 256 flag patterns with start or terminate characters placed at every byte, so every legal layout is reached, along with its nearest illegal variants.

// File: rtl/blkgen_pkg.sv
package blkgen_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = 8;
  localparam int unsigned DATA_W  = BYTE_W * N_BYTES;
  localparam int unsigned TYPE_W  = 4;
  localparam int unsigned S4_POS  = N_BYTES / 2;

  localparam logic [TYPE_W-1:0] TY_DATA   = 4'b0000;
  localparam logic [TYPE_W-1:0] TY_START0 = 4'b1001;
  localparam logic [TYPE_W-1:0] TY_START4 = 4'b1010;
  localparam logic [TYPE_W-1:0] TY_ALIGN  = 4'b1011;
  localparam logic [TYPE_W-1:0] TY_ERROR  = 4'b1100;
  localparam logic [TYPE_W-1:0] TY_NULL   = 4'b1101;
  localparam logic [TYPE_W-1:0] TY_OSET   = 4'b1110;
  localparam logic [TYPE_W-1:0] TY_CTRL   = 4'b1111;

  localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
  localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
  localparam logic [BYTE_W-1:0] CH_ERR   = 8'hFE;
  localparam logic [BYTE_W-1:0] CH_ALIGN = 8'h7C;
  localparam logic [BYTE_W-1:0] CH_NULL  = 8'h9C;
endpackage

// File: rtl/blkgen_byte_class.sv
module blkgen_byte_class
  import blkgen_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              flag_i,
  output logic              start_o,
  output logic              term_o,
  output logic              plain_o,
  output logic              align_o,
  output logic              null_o,
  output logic              err_o
);
  always_comb begin
    start_o = flag_i && (byte_i == CH_START);
    term_o  = flag_i && (byte_i == CH_TERM);
    plain_o = flag_i && !start_o && !term_o;
    align_o = flag_i && (byte_i == CH_ALIGN);
    null_o  = flag_i && (byte_i == CH_NULL);
    err_o   = flag_i && (byte_i == CH_ERR);
  end
endmodule

// File: rtl/blkgen_type_enc.sv
module blkgen_type_enc
  import blkgen_pkg::*;
(
  input  logic [N_BYTES-1:0] flag_i,
  input  logic [N_BYTES-1:0] start_i,
  input  logic [N_BYTES-1:0] term_i,
  input  logic [N_BYTES-1:0] plain_i,
  input  logic [N_BYTES-1:0] align_i,
  input  logic [N_BYTES-1:0] null_i,
  input  logic [N_BYTES-1:0] err_i,
  output logic [TYPE_W-1:0]  type_o,
  output logic               illegal_o
);
  localparam logic [N_BYTES-1:0] ALL1  = {N_BYTES{1'b1}};
  localparam logic [N_BYTES-1:0] S4_MS = ALL1 >> (N_BYTES - S4_POS - 1);

  logic [N_BYTES-1:0] term_hit;
  logic               s0_hit, s4_hit;

  // terminate at k: data below k, terminate at k, plain control above k
  for (genvar k = 0; k < N_BYTES; k++) begin : g_term
    localparam logic [N_BYTES-1:0] MASK = ALL1 << k;
    logic tail_ok;
    if (k == N_BYTES - 1) begin : g_last
      assign tail_ok = 1'b1;
    end else begin : g_tail
      assign tail_ok = &plain_i[N_BYTES-1:k+1];
    end
    assign term_hit[k] = (flag_i == MASK) && term_i[k] && tail_ok;
  end

  assign s0_hit = (flag_i == N_BYTES'(1)) && start_i[0];
  assign s4_hit = (flag_i == S4_MS) && start_i[S4_POS] && (&plain_i[S4_POS-1:0]);

  always_comb begin
    type_o    = TY_ERROR;
    illegal_o = 1'b0;
    if (flag_i == '0)            type_o = TY_DATA;
    else if (s0_hit)             type_o = TY_START0;
    else if (s4_hit)             type_o = TY_START4;
    else if (|term_hit) begin
      for (int k = 0; k < N_BYTES; k++)
        if (term_hit[k]) type_o = TYPE_W'(N_BYTES - k);
    end
    else if (&align_i)           type_o = TY_ALIGN;
    else if (&null_i)            type_o = TY_NULL;
    else if (&err_i)             type_o = TY_ERROR;
    else if (&plain_i)           type_o = TY_CTRL;
    else                         illegal_o = 1'b1;
  end
endmodule

// File: rtl/blk_type_gen.sv
module blk_type_gen
  import blkgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [63:0]       data_i,
  input  logic [7:0]        ctrl_i,
  output logic              valid_o,
  output logic [63:0]       block_o,
  output logic [3:0]        type_o
);
  logic [N_BYTES-1:0] start_w, term_w, plain_w, align_w, null_w, err_w;
  logic [TYPE_W-1:0]  type_w;
  logic               illegal_w;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    blkgen_byte_class u_cls (
      .byte_i  (data_i[BYTE_W*i +: BYTE_W]),
      .flag_i  (ctrl_i[i]),
      .start_o (start_w[i]),
      .term_o  (term_w[i]),
      .plain_o (plain_w[i]),
      .align_o (align_w[i]),
      .null_o  (null_w[i]),
      .err_o   (err_w[i])
    );
  end

  blkgen_type_enc u_enc (
    .flag_i    (ctrl_i),
    .start_i   (start_w),
    .term_i    (term_w),
    .plain_i   (plain_w),
    .align_i   (align_w),
    .null_i    (null_w),
    .err_i     (err_w),
    .type_o    (type_w),
    .illegal_o (illegal_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      block_o <= '0;
      type_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        type_o  <= type_w;
        block_o <= illegal_w ? {N_BYTES{CH_ERR}} : data_i;
      end
    end
  end
endmodule

// File: rtl/blk_type_gen_chk.sv
module blk_type_gen_chk
  import blkgen_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [63:0] data_i,
  input logic [7:0]  ctrl_i,
  input logic        valid_o,
  input logic [63:0] block_o,
  input logic [3:0]  type_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("AST_VALID_RISE"); // R2
  AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("AST_VALID_FALL"); // R2
  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i == 8'h00) |=> (type_o == TY_DATA && block_o == $past(data_i)))
    else $error("AST_DATA_PASS"); // R3
  AST_START0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i == 8'h01 && data_i[7:0] == CH_START) |=> (type_o == TY_START0))
    else $error("AST_START0"); // R4
  AST_ERR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && type_o == TY_ERROR) |-> (block_o == {N_BYTES{CH_ERR}}))
    else $error("AST_ERR_FILL"); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(type_o) && $stable(block_o))) else $error("AST_HOLD"); // R10
  AST_NO_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (type_o != TY_OSET)) else $error("AST_NO_RSVD"); // R11
endmodule

bind blk_type_gen blk_type_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .data_i  (data_i),
  .ctrl_i  (ctrl_i),
  .valid_o (valid_o),
  .block_o (block_o),
  .type_o  (type_o)
);

// File: tb/blk_type_gen_tb.sv
`timescale 1ns/1ps
module blk_type_gen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] data_i = '0;
  logic [7:0]  ctrl_i = '0;
  logic        valid_o;
  logic [63:0] block_o;
  logic [3:0]  type_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  blk_type_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .ctrl_i(ctrl_i), .valid_o(valid_o), .block_o(block_o), .type_o(type_o)
  );

  // reference from the requirements: returns {illegal, type}
  function automatic logic [4:0] model(input logic [7:0] c, input logic [63:0] d);
    logic [7:0] b [8];
    logic [7:0] pl;
    bit all_a, all_n, all_e;
    for (int i = 0; i < 8; i++) begin
      b[i] = d[8*i +: 8];
      pl[i] = c[i] && b[i] != 8'hFB && b[i] != 8'hFD;
    end
    if (c == 8'h00) return 5'h00;
    if (c == 8'h01 && b[0] == 8'hFB) return 5'h09;
    if (c == 8'h1F && b[4] == 8'hFB && pl[3:0] == 4'hF) return 5'h0A;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] m;
      bit ok;
      m = 8'hFF << k;
      ok = (c == m) && b[k] == 8'hFD;
      for (int j = k + 1; j < 8; j++) if (!pl[j]) ok = 0;
      if (ok) return {1'b0, 4'(8 - k)};
    end
    all_a = (c == 8'hFF); all_n = all_a; all_e = all_a;
    for (int i = 0; i < 8; i++) begin
      if (b[i] != 8'h7C) all_a = 0;
      if (b[i] != 8'h9C) all_n = 0;
      if (b[i] != 8'hFE) all_e = 0;
    end
    if (all_a) return 5'h0B;
    if (all_n) return 5'h0D;
    if (all_e) return 5'h0C;
    if (pl == 8'hFF) return 5'h0F;
    return 5'h1C;
  endfunction

  function automatic string tag_of(input logic [4:0] m);
    if (m[4]) return "R9";
    case (m[3:0])
      4'h0: return "R3";
      4'h9: return "R4";
      4'hA: return "R5";
      4'hF: return "R7";
      4'hB, 4'hC, 4'hD: return "R8";
      default: return "R6";
    endcase
  endfunction

  logic [63:0] last_blk;
  logic [3:0]  last_ty;

  task automatic apply(input logic [7:0] c, input logic [63:0] d);
    logic [4:0]  m;
    logic [63:0] eb;
    m  = model(c, d);
    eb = m[4] ? {8{8'hFE}} : d;
    @(negedge clk);
    valid_i = 1'b1; ctrl_i = c; data_i = d;
    @(negedge clk);
    tests++;
    if (!(valid_o === 1'b1 && type_o === m[3:0] && block_o === eb)) begin
      fails++;
      $display("FAIL %s/R2 ctrl=%h data=%h: got v=%b t=%h b=%h exp v=1 t=%h b=%h",
               tag_of(m), c, d, valid_o, type_o, block_o, m[3:0], eb);
    end
    tests++;
    if (type_o === 4'hE) begin
      fails++;
      $display("FAIL R11 ctrl=%h: got t=%h exp not e", c, type_o);
    end
    last_blk = eb; last_ty = m[3:0];
  endtask

  task automatic idle_check();
    @(negedge clk);
    valid_i = 1'b0; ctrl_i = ~ctrl_i; data_i = ~data_i;
    @(negedge clk);
    tests++;
    if (!(valid_o === 1'b0 && type_o === last_ty && block_o === last_blk)) begin
      fails++;
      $display("FAIL R10/R2: got v=%b t=%h b=%h exp v=0 t=%h b=%h",
               valid_o, type_o, block_o, last_ty, last_blk);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] c, input int mark, input int p, input int s);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) begin
      if (mark != 0 && i == p) d[8*i +: 8] = (mark == 1) ? 8'hFB : 8'hFD;
      else if (c[i])          d[8*i +: 8] = 8'h07;
      else                    d[8*i +: 8] = 8'(s * 37 + i * 11 + 1);
    end
    return d;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (!(valid_o === 1'b0 && type_o === 4'h0 && block_o === 64'h0)) begin
      fails++;
      $display("FAIL R1: got v=%b t=%h b=%h exp 0 0 0", valid_o, type_o, block_o);
    end
    rst_ni = 1'b1;
    // R8 uniform special blocks and a mixed one (R7)
    apply(8'hFF, {8{8'h7C}});
    apply(8'hFF, {8{8'h9C}});
    apply(8'hFF, {8{8'hFE}});
    apply(8'hFF, {{7{8'h9C}}, 8'h07});
    idle_check();
    // sweep all flag patterns with markers at every byte
    for (int c = 0; c < 256; c++) begin
      apply(8'(c), mk(8'(c), 0, 0, c));
      for (int mark = 1; mark < 3; mark++)
        for (int p = 0; p < 8; p++)
          apply(8'(c), mk(8'(c), mark, p, c + p));
      if (c % 16 == 0) idle_check();
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule